// File: doc/BRIEF.md
# Feed-Forward Timer-Based Bus Regulator PWM

This block drives the gates of two synchronous buck stages that share the load on a regulated output bus. Both stages run at the same switching frequency. The second stage runs half a period behind the first, so the two input ripple currents partly cancel. The duty cycle is set feed-forward from the input (solar-array) voltage, with no feedback loop. An RC timer measures that voltage. The block shorts the timing capacitor for a fixed number of clocks, releases it, and counts clocks until an external comparator reports that the capacitor has reached its threshold. A higher array voltage charges the capacitor faster and gives a shorter count. The count is therefore proportional to the duty cycle needed for a fixed output voltage.

The count is checked against a valid window, then scaled by a fixed gain. A signed calibration offset is added, and the result is clamped to the normal duty range. Each stage adopts the new pulse width only at the start of its own switching period. Two timer circuits are fitted for redundancy, and a power-cycle pulse moves measurement to the other one. A bypass (eclipse) input forces full conduction on both high-side gates. An over-voltage input and the per-FET disable inputs remove individual gates.

Top module: `ffbus_pwm`

## Requirements
- R1: While reset is low and directly after it rises, `hs_o` and `ls_o` are 0 and `err_o` is 0. Timer 0 is selected and in its discharge phase, so `dis_o` = 2'b01.
- R2: A measurement holds the selected timer's discharge line high for DISCH_CYC clock edges. It then counts one per clock while that timer's comparator is low. The count T is the number of clocks from the release of discharge until the comparator is seen high.
- R3: A valid count T gives the width W = ((T*GAIN) >> GAIN_SHIFT) + ofs_i, clamped per R4. In each period the high-side gate is on for W-DEAD clocks and the low-side gate for PERIOD-W-DEAD clocks.
- R4: Outside bypass, W is clamped to the range PERIOD*DMIN_PCT/100 to PERIOD*DMAX_PCT/100 (50 % to 95 % by default).
- R5: A count below CNT_MIN, or no comparator trip by the time the count reaches CNT_MAX, is invalid. An invalid count leaves the width unchanged and sets `err_o`. The next valid count clears `err_o`.
- R6: A stage loads a new width only when its own period starts. A width that changes mid-period takes effect in the following period.
- R7: Stage 1 (bit 1 of `hs_o`/`ls_o`) switches PERIOD/2 clocks after stage 0.
- R8: Within a stage, the high-side and low-side gates are never on together. Outside bypass, each hand-over between them includes DEAD clocks with both off, so each period has 2*DEAD such clocks.
- R9: With `bypass_i` high, both high-side gates are held on and both low-side gates off. This is 100 % duty.
- R10: If either bit of `ov_i` is high, both high-side gates are off from the next clock on. The low-side gates keep their schedule.
- R11: `ls_dis_i[i]` forces low-side gate i off. `hs_dis_b_i` forces the high-side gate of stage 1 off. Each takes effect from the next clock.
- R12: A pulse on `pcyc_i` swaps to the other timer and restarts measurement in discharge. On the next clock, `dis_o` shows only the newly selected timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 2 | Comparator trip per timer, synchronous to clk_i |
| dis_o | output | 2 | Capacitor discharge command per timer |
| pcyc_i | input | 1 | Power-cycle pulse; swaps the active timer |
| ofs_i | input | OFS_W | Signed calibration offset added to the width, in clocks |
| bypass_i | input | 1 | Bypass/eclipse: force 100 % duty |
| ov_i | input | 2 | Over-voltage detectors; either one turns off both high-side gates |
| ls_dis_i | input | 2 | Low-side gate disable per stage |
| hs_dis_b_i | input | 1 | High-side gate disable for stage 1 |
| hs_o | output | 2 | High-side gate commands |
| ls_o | output | 2 | Low-side gate commands |
| err_o | output | 1 | Last timer result was out of range |

## Verification
The gate outputs are registered, so a change on `bypass_i`, `ov_i` or the disable inputs appears one clock after it is sampled. The bench waits at least one falling edge before it samples. A new count is registered one clock after the comparator trip. It reaches the gates only at the next period start of each stage, so every width check first waits several periods and then counts gate-on clocks over exactly one period. That window is anchored at a rising edge of `hs_o[0]`, which makes the counts independent of phase. `err_o` and `dis_o` are due one clock after a result or a power-cycle pulse, and they are sampled on the falling edge after that.

// File: rtl/ffbus_pkg.sv
`timescale 1ns/1ps
package ffbus_pkg;
   typedef enum logic [0:0] {
      TM_DISCH = 1'b0,
      TM_COUNT = 1'b1
   } tm_state_e;
endpackage

// File: rtl/ffbus_timer.sv
`timescale 1ns/1ps
// Charge-time measurement on one of two redundant RC timers.
module ffbus_timer
   import ffbus_pkg::*;
#(
   parameter int CNT_W     = 14,
   parameter int CNT_MIN   = 100,
   parameter int CNT_MAX   = 12000,
   parameter int DISCH_CYC = 40
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pcyc_i,
   input  logic [1:0]       cmp_i,
   output logic [1:0]       dis_o,
   output logic             vld_o,
   output logic             ok_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int DW = $clog2(DISCH_CYC + 1);

   tm_state_e        state_q;
   logic             sel_q;
   logic [DW-1:0]    dcnt_q;
   logic [CNT_W-1:0] cnt_q;
   logic             trip;

   assign trip  = cmp_i[sel_q];
   assign dis_o = (state_q == TM_DISCH) ? (sel_q ? 2'b10 : 2'b01) : 2'b00;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= TM_DISCH;
         sel_q   <= 1'b0;
         dcnt_q  <= '0;
         cnt_q   <= '0;
         vld_o   <= 1'b0;
         ok_o    <= 1'b0;
         cnt_o   <= '0;
      end else begin
         vld_o <= 1'b0;
         if (pcyc_i) begin
            sel_q   <= ~sel_q;
            state_q <= TM_DISCH;
            dcnt_q  <= '0;
            cnt_q   <= '0;
         end else begin
            unique case (state_q)
               TM_DISCH: begin
                  if (dcnt_q == DW'(DISCH_CYC - 1)) begin
                     state_q <= TM_COUNT;
                     dcnt_q  <= '0;
                     cnt_q   <= '0;
                  end else begin
                     dcnt_q <= dcnt_q + 1'b1;
                  end
               end
               TM_COUNT: begin
                  if (trip) begin
                     vld_o   <= 1'b1;
                     ok_o    <= (cnt_q >= CNT_W'(CNT_MIN));
                     cnt_o   <= cnt_q;
                     state_q <= TM_DISCH;
                  end else if (cnt_q == CNT_W'(CNT_MAX)) begin
                     vld_o   <= 1'b1;
                     ok_o    <= 1'b0;
                     cnt_o   <= cnt_q;
                     state_q <= TM_DISCH;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= TM_DISCH;
            endcase
         end
      end
   end
endmodule

// File: rtl/ffbus_width.sv
`timescale 1ns/1ps
// Count to pulse width: gain, signed trim, clamp, hold on bad result.
module ffbus_width #(
   parameter int CNT_W      = 14,
   parameter int OFS_W      = 8,
   parameter int PW         = 12,
   parameter int GAIN       = 1,
   parameter int GAIN_SHIFT = 1,
   parameter int WMIN       = 2000,
   parameter int WMAX       = 3800
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    vld_i,
   input  logic                    ok_i,
   input  logic [CNT_W-1:0]        cnt_i,
   input  logic signed [OFS_W-1:0] ofs_i,
   output logic [PW-1:0]           pend_o,
   output logic                    have_o,
   output logic                    err_o
);
   int scaled, trimmed, clipped;

   always_comb begin
      scaled  = (int'(cnt_i) * GAIN) >>> GAIN_SHIFT;
      trimmed = scaled + int'(ofs_i);
      if (trimmed < WMIN)      clipped = WMIN;
      else if (trimmed > WMAX) clipped = WMAX;
      else                     clipped = trimmed;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_o <= PW'(WMIN);
         have_o <= 1'b0;
         err_o  <= 1'b0;
      end else if (vld_i) begin
         err_o <= ~ok_i;
         if (ok_i) begin
            pend_o <= PW'(clipped);
            have_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ffbus_phase.sv
`timescale 1ns/1ps
// One switching stage: period counter, boundary load, dead-time gating.
module ffbus_phase #(
   parameter int PERIOD = 4000,
   parameter int PW     = 12,
   parameter int DEAD   = 20,
   parameter int START  = 0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [PW-1:0] pend_i,
   input  logic          have_i,
   input  logic          bypass_i,
   input  logic          hs_kill_i,
   input  logic          ls_kill_i,
   output logic          hs_o,
   output logic          ls_o
);
   logic [PW-1:0] ctr_q;
   logic [PW-1:0] act_w_q;
   logic          act_on_q;
   logic          wrap;
   logic          hs_n, ls_n;

   assign wrap = (ctr_q == PW'(PERIOD - 1));

   always_comb begin
      hs_n = bypass_i |
             (act_on_q && (ctr_q >= PW'(DEAD)) && (ctr_q < act_w_q));
      ls_n = ~bypass_i && act_on_q &&
             ({1'b0, ctr_q} >= ({1'b0, act_w_q} + (PW+1)'(DEAD)));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctr_q    <= PW'(START);
         act_w_q  <= '0;
         act_on_q <= 1'b0;
         hs_o     <= 1'b0;
         ls_o     <= 1'b0;
      end else begin
         ctr_q <= wrap ? '0 : ctr_q + 1'b1;
         if (wrap) begin
            act_w_q  <= pend_i;
            act_on_q <= have_i;
         end
         hs_o <= hs_n & ~hs_kill_i;
         ls_o <= ls_n & ~ls_kill_i;
      end
   end
endmodule

// File: rtl/ffbus_pwm.sv
`timescale 1ns/1ps
module ffbus_pwm #(
   parameter int PERIOD     = 4000,
   parameter int DEAD       = 20,
   parameter int DMIN_PCT   = 50,
   parameter int DMAX_PCT   = 95,
   parameter int DISCH_CYC  = 40,
   parameter int CNT_W      = 14,
   parameter int CNT_MIN    = 100,
   parameter int CNT_MAX    = 12000,
   parameter int GAIN       = 1,
   parameter int GAIN_SHIFT = 1,
   parameter int OFS_W      = 8
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [1:0]              cmp_i,
   output logic [1:0]              dis_o,
   input  logic                    pcyc_i,
   input  logic signed [OFS_W-1:0] ofs_i,
   input  logic                    bypass_i,
   input  logic [1:0]              ov_i,
   input  logic [1:0]              ls_dis_i,
   input  logic                    hs_dis_b_i,
   output logic [1:0]              hs_o,
   output logic [1:0]              ls_o,
   output logic                    err_o
);
   localparam int HALF = PERIOD / 2;
   localparam int WMIN = PERIOD * DMIN_PCT / 100;
   localparam int WMAX = PERIOD * DMAX_PCT / 100;
   localparam int PW   = $clog2(PERIOD + 1);

   if (PERIOD % 2 != 0) begin : g_bad_period
      $error("PERIOD must be even for half-period interleave");
   end
   if (WMIN <= DEAD) begin : g_bad_wmin
      $error("minimum width must exceed the dead time");
   end
   if (WMAX + DEAD >= PERIOD) begin : g_bad_wmax
      $error("maximum width plus dead time must stay below PERIOD");
   end
   if (CNT_MAX >= (1 << CNT_W) || CNT_MIN > CNT_MAX) begin : g_bad_cnt
      $error("count window does not fit CNT_W");
   end
   if (GAIN < 1 || GAIN > 255 || DISCH_CYC < 1) begin : g_bad_misc
      $error("GAIN or DISCH_CYC out of range");
   end

   logic             res_vld, res_ok;
   logic [CNT_W-1:0] res_cnt;
   logic [PW-1:0]    pend_w;
   logic             have_w;
   logic             ov_any;
   logic [1:0]       hs_kill;

   assign ov_any = |ov_i;

   ffbus_timer #(
      .CNT_W(CNT_W), .CNT_MIN(CNT_MIN), .CNT_MAX(CNT_MAX), .DISCH_CYC(DISCH_CYC)
   ) i_timer (
      .clk_i(clk_i), .rst_ni(rst_ni), .pcyc_i(pcyc_i), .cmp_i(cmp_i),
      .dis_o(dis_o), .vld_o(res_vld), .ok_o(res_ok), .cnt_o(res_cnt)
   );

   ffbus_width #(
      .CNT_W(CNT_W), .OFS_W(OFS_W), .PW(PW), .GAIN(GAIN),
      .GAIN_SHIFT(GAIN_SHIFT), .WMIN(WMIN), .WMAX(WMAX)
   ) i_width (
      .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(res_vld), .ok_i(res_ok),
      .cnt_i(res_cnt), .ofs_i(ofs_i), .pend_o(pend_w), .have_o(have_w),
      .err_o(err_o)
   );

   for (genvar g = 0; g < 2; g++) begin : g_ph
      localparam int START = (g == 0) ? 0 : PERIOD - HALF;
      assign hs_kill[g] = ov_any | ((g == 1) && hs_dis_b_i);
      ffbus_phase #(
         .PERIOD(PERIOD), .PW(PW), .DEAD(DEAD), .START(START)
      ) i_phase (
         .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_w), .have_i(have_w),
         .bypass_i(bypass_i), .hs_kill_i(hs_kill[g]), .ls_kill_i(ls_dis_i[g]),
         .hs_o(hs_o[g]), .ls_o(ls_o[g])
      );
   end
endmodule

// File: rtl/ffbus_chk.sv
`timescale 1ns/1ps
module ffbus_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       bypass_i,
   input logic       pcyc_i,
   input logic       hs_dis_b_i,
   input logic [1:0] ov_i,
   input logic [1:0] ls_dis_i,
   input logic [1:0] dis_o,
   input logic [1:0] hs_o,
   input logic [1:0] ls_o
);
   logic [1:0] armed;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed <= '0;
      else         armed <= {armed[0], 1'b1};
   end

   for (genvar i = 0; i < 2; i++) begin : g_st
      AST_HS_LS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !(hs_o[i] && ls_o[i])); // R8
      AST_DEAD_HS_TO_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (armed[1] && !$past(bypass_i) && !$past(bypass_i, 2) && $past(hs_o[i]))
         |-> !ls_o[i]); // R8
      AST_DEAD_LS_TO_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (armed[1] && !$past(bypass_i) && !$past(bypass_i, 2) && $past(ls_o[i]))
         |-> !hs_o[i]); // R8
      AST_LS_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (armed[0] && $past(ls_dis_i[i])) |-> !ls_o[i]); // R11
   end

   AST_BYPASS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed[0] && $past(bypass_i) && ($past(ov_i) == 2'b00) && !$past(hs_dis_b_i))
      |-> (hs_o == 2'b11 && ls_o == 2'b00)); // R9
   AST_OV_HS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed[0] && ($past(ov_i) != 2'b00)) |-> (hs_o == 2'b00)); // R10
   AST_HS_B_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed[0] && $past(hs_dis_b_i)) |-> !hs_o[1]); // R11
   AST_TIMER_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed[0] && $past(pcyc_i)) |-> (dis_o != 2'b00 && dis_o != $past(dis_o))); // R12
endmodule

bind ffbus_pwm ffbus_chk i_ffbus_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .bypass_i(bypass_i), .pcyc_i(pcyc_i),
   .hs_dis_b_i(hs_dis_b_i), .ov_i(ov_i), .ls_dis_i(ls_dis_i), .dis_o(dis_o),
   .hs_o(hs_o), .ls_o(ls_o)
);

// File: tb/test_ffbus_pwm.sv
`timescale 1ns/1ps
module test_ffbus_pwm;
   localparam int P     = 100;
   localparam int DEAD  = 2;
   localparam int DISCH = 4;
   localparam int HALF  = P / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cmp, dis, hs_o, ls_o;
   logic [1:0] ov = 2'b00, ls_dis = 2'b00;
   logic pcyc = 1'b0, bypass = 1'b0, hs_dis_b = 1'b0, err;
   logic signed [5:0] ofs = 6'sd0;

   int tset[2] = '{100, 100};
   int mcap[2] = '{0, 0};
   int tlat[2] = '{0, 0};
   int checks = 0, errors = 0, cyc = 0;
   int mh0, ml0, mh1, ml1, mrb, movl, moff, mfound;

   always #2.5 clk = ~clk;

   ffbus_pwm #(
      .PERIOD(P), .DEAD(DEAD), .DMIN_PCT(50), .DMAX_PCT(95), .DISCH_CYC(DISCH),
      .CNT_W(8), .CNT_MIN(20), .CNT_MAX(200), .GAIN(3), .GAIN_SHIFT(2), .OFS_W(6)
   ) i_ffbus_pwm (
      .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .dis_o(dis), .pcyc_i(pcyc),
      .ofs_i(ofs), .bypass_i(bypass), .ov_i(ov), .ls_dis_i(ls_dis),
      .hs_dis_b_i(hs_dis_b), .hs_o(hs_o), .ls_o(ls_o), .err_o(err)
   );

   // RC timer model: trips tlat clocks after discharge is released
   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (dis[i]) begin
            mcap[i] <= 0;
            tlat[i] <= tset[i];
         end else if (mcap[i] < 1000) begin
            mcap[i] <= mcap[i] + 1;
         end
      end
   end
   always_comb begin
      for (int i = 0; i < 2; i++) cmp[i] = !dis[i] && (mcap[i] >= tlat[i]);
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4 * P + 250) @(negedge clk);
   endtask

   task automatic clear_counts();
      mh0 = 0; ml0 = 0; mh1 = 0; ml1 = 0; mrb = -1; movl = 0; moff = 0;
   endtask

   task automatic sample_once(input int k, inout logic pb);
      if (hs_o[0]) mh0++;
      if (ls_o[0]) ml0++;
      if (hs_o[1]) mh1++;
      if (ls_o[1]) ml1++;
      if (k > 0 && hs_o[1] && !pb && mrb < 0) mrb = k;
      pb = hs_o[1];
      if (!hs_o[0] && !ls_o[0]) moff++;
      if ((hs_o & ls_o) != 2'b00) movl++;
   endtask

   // one full period anchored at a rising edge of hs_o[0]
   task automatic measure(input bit poke, input logic signed [5:0] poke_val);
      logic prev, pb;
      int lim;
      mfound = 0; lim = 0; prev = hs_o[0];
      clear_counts();
      while (mfound == 0 && lim < 3 * P) begin
         @(negedge clk);
         if (hs_o[0] && !prev) mfound = 1;
         else begin prev = hs_o[0]; lim++; end
      end
      if (mfound != 0 && poke) ofs = poke_val;
      pb = hs_o[1];
      if (mfound != 0) begin
         for (int k = 0; k < P; k++) begin
            sample_once(k, pb);
            @(negedge clk);
         end
      end
   endtask

   task automatic window();
      logic pb;
      clear_counts();
      pb = hs_o[1];
      for (int k = 0; k < P; k++) begin
         sample_once(k, pb);
         @(negedge clk);
      end
   endtask

   task automatic expect_period(input string tag, input int w);
      measure(1'b0, 6'sd0);
      chk({tag, " edge found"}, mfound, 1);
      chk({tag, " hs0 on"}, mh0, w - DEAD);
      chk({tag, " ls0 on"}, ml0, P - w - DEAD);
      chk({tag, " hs1 on"}, mh1, w - DEAD);
      chk({tag, " ls1 on"}, ml1, P - w - DEAD);
      chk({tag, " R7 stage1 delay"}, mrb, HALF);
      chk({tag, " R8 overlap"}, movl, 0);
      chk({tag, " R8 both-off clocks"}, moff, 2 * DEAD);
   endtask

   task automatic t_reset();
      int n;
      repeat (3) @(negedge clk);
      chk("R1 hs in reset", int'(hs_o), 0);
      chk("R1 ls in reset", int'(ls_o), 0);
      rst_n = 1'b1;
      chk("R1 hs after release", int'(hs_o), 0);
      chk("R1 ls after release", int'(ls_o), 0);
      chk("R1 err after release", int'(err), 0);
      chk("R1 dis after release", int'(dis), 1);
      n = 0;
      @(negedge clk);
      while (dis[0] && n < 50) begin n++; @(negedge clk); end
      chk("R2 discharge clocks after release", n, DISCH - 1);
   endtask

   task automatic t_width();
      settle();
      expect_period("R3 T100", 75);
      tset[0] = 80; ofs = 6'sd5; settle();
      expect_period("R3 T80 ofs+5", 65);
      tset[0] = 120; ofs = -6'sd10; settle();
      expect_period("R3 T120 ofs-10", 80);
      tset[0] = 160; ofs = 6'sd0; settle();
      expect_period("R4 clamp high", 95);
      tset[0] = 40; settle();
      expect_period("R4 clamp low", 50);
      tset[0] = 100; settle();
   endtask

   task automatic t_load();
      measure(1'b1, 6'sd10);
      chk("R6 edge found", mfound, 1);
      chk("R6 current period keeps width", mh0, 75 - DEAD);
      settle();
      expect_period("R6 next period", 85);
      ofs = 6'sd0; settle();
   endtask

   task automatic t_err();
      tset[0] = 10;
      repeat (150) @(negedge clk);
      chk("R5 err on short count", int'(err), 1);
      settle();
      expect_period("R5 held after short", 75);
      tset[0] = 100; settle();
      chk("R5 err cleared", int'(err), 0);
      tset[0] = 250;
      repeat (350) @(negedge clk);
      chk("R5 err on timeout", int'(err), 1);
      expect_period("R5 held after timeout", 75);
      tset[0] = 100; settle();
   endtask

   task automatic t_bypass();
      bypass = 1'b1;
      repeat (2) @(negedge clk);
      window();
      chk("R9 hs0 full", mh0, P);
      chk("R9 hs1 full", mh1, P);
      chk("R9 ls off", ml0 + ml1, 0);
      bypass = 1'b0; settle();
   endtask

   task automatic t_ov();
      ov = 2'b10;
      repeat (2) @(negedge clk);
      window();
      chk("R10 hs off", mh0 + mh1, 0);
      chk("R10 ls0 unchanged", ml0, P - 75 - DEAD);
      ov = 2'b00; settle();
      expect_period("R10 recovered", 75);
   endtask

   task automatic t_dis();
      ls_dis = 2'b01;
      repeat (2) @(negedge clk);
      measure(1'b0, 6'sd0);
      chk("R11 ls0 disabled", ml0, 0);
      chk("R11 ls1 active", ml1, P - 75 - DEAD);
      chk("R11 hs0 active", mh0, 75 - DEAD);
      ls_dis = 2'b00; hs_dis_b = 1'b1;
      repeat (2) @(negedge clk);
      measure(1'b0, 6'sd0);
      chk("R11 hs1 disabled", mh1, 0);
      chk("R11 hs0 still on", mh0, 75 - DEAD);
      chk("R11 ls1 still on", ml1, P - 75 - DEAD);
      hs_dis_b = 1'b0; settle();
   endtask

   task automatic t_swap();
      tset[1] = 80;
      pcyc = 1'b1;
      @(negedge clk);
      pcyc = 1'b0;
      chk("R12 timer1 discharging", int'(dis), 2);
      settle();
      expect_period("R12 timer1 width", 60);
      pcyc = 1'b1;
      @(negedge clk);
      pcyc = 1'b0;
      chk("R12 timer0 discharging", int'(dis), 1);
      settle();
      expect_period("R12 timer0 width", 75);
   endtask

   initial begin
      t_reset();
      t_width();
      t_load();
      t_err();
      t_bypass();
      t_ov();
      t_dis();
      t_swap();
      summary();
      $finish;
   end
endmodule